// File: doc/BRIEF.md
# PLL Rate Configuration Calculator

This block turns a requested per-lane serial bit rate (kbps) and a reference clock frequency (kHz) into the packed 16-bit setting word for a bridge PLL. The word holds three fields: the input divider, the feedback multiplier and a frequency-band code. The block also returns the output rate that this setting really produces. From that rate it derives the 6-bit divider code for the low-power escape clock, which runs at no more than 10 MHz.

A pulse on `start` latches both inputs. The engine then runs as a multi-cycle sequence. It first searches upward for the input divider. Next it performs three divisions in turn on one shared restoring divider, which makes one quotient bit per clock. These give the multiplier, the actual rate and the low-power divider. When every output is valid, `done` pulses for one cycle. The outputs then hold their values until the next result is ready. All arithmetic is unsigned integer.

Top module: `pll_rate_calc`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `mul_ovf`, `cfg_word`, `actual_kbps` and `lp_div_code` are all zero.
- R2: Divider search:
  - The divider D starts at 1.
  - D is incremented while floor(ref / (D+1)) >= 5000.
  - D stops at 31.
  - D appears in `cfg_word[12:8]`.
- R3: The multiplier M is ceil(target × D / ref). It appears in `cfg_word[7:0]`.
- R4: If the multiplier would exceed 255, `cfg_word[7:0]` is 255 and `mul_ovf` is 1. Otherwise `mul_ovf` is 0.
- R5: `actual_kbps` is floor(ref × M' / D). M' is the 8-bit multiplier field, with a zero field counted as 1.
- R6: The band code is taken from `actual_kbps`, not from the target. It sits in `cfg_word[15:14]`, and `cfg_word[13]` is 0. The code values are:
  - 3 when `actual_kbps` >= 501000.
  - 2 when `actual_kbps` >= 251000.
  - 1 when `actual_kbps` >= 126000.
  - 0 otherwise.
- R7: `lp_div_code` is (ceil(`actual_kbps` / 80000) − 1) mod 64.
- R8: Timing:
  - `busy` rises on the clock edge that accepts `start`.
  - `done` is a one-cycle pulse, raised on the same edge on which `busy` falls.
  - `done` follows the accepting edge by D + 3·(RATE_W+12) cycles, which is D + 132 at default width.
- R9: While `busy` is high, `start` and changes on `target_kbps`/`ref_khz` have no effect. The result is computed from the inputs latched when the run was accepted.
- R10: The result outputs change only on the cycle in which `done` is high. Otherwise they hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new calculation (honoured when idle) |
| target_kbps | input | RATE_W | Requested per-lane bit rate in kbps |
| ref_khz | input | RATE_W | Reference clock in kHz, must be nonzero |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| cfg_word | output | 16 | {band[1:0], 0, divider[4:0], multiplier[7:0]} |
| actual_kbps | output | RATE_W+10 | Rate produced by the chosen setting |
| lp_div_code | output | 6 | Low-power clock divider code |
| mul_ovf | output | 1 | Multiplier saturated at 255 |

## Verification
The assertions assume the following about the inputs:
- `ref_khz` is nonzero, so no division by zero reaches the shared divider.
- `target_kbps` is small enough that target × 31 + ref fits the 42-bit numerator.
- `start` may be raised at any time, including during a run.

The stimulus keeps references in the 1 MHz to 200 MHz range and targets below 10 Gbps. It covers:
- runs that stop the divider search at once;
- runs that hit the clamp at 31;
- exact band and low-power boundaries;
- a zero target;
- multiplier saturation;
- a mid-run `start` carrying different operands.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEARCH, ST_MUL_GO, ST_MUL_WAIT,
    ST_ACT_GO, ST_ACT_WAIT, ST_LP_GO, ST_LP_WAIT
  } calc_state_t;

  // Band thresholds on the achieved rate (kbps)
  localparam int unsigned BAND3_KBPS = 501000;
  localparam int unsigned BAND2_KBPS = 251000;
  localparam int unsigned BAND1_KBPS = 126000;
endpackage

// File: rtl/pll_band_enc.sv
module pll_band_enc
  import pll_calc_pkg::*;
#(
  parameter int ACT_W = 42
) (
  input  logic [ACT_W-1:0] rate,
  output logic [1:0]       band
);
  always_comb begin
    if (rate >= ACT_W'(BAND3_KBPS))      band = 2'd3;
    else if (rate >= ACT_W'(BAND2_KBPS)) band = 2'd2;
    else if (rate >= ACT_W'(BAND1_KBPS)) band = 2'd1;
    else                                 band = 2'd0;
  end
endmodule

// File: rtl/pll_seq_div.sv
// Restoring divider: one quotient bit per clock, NW steps per division.
module pll_seq_div #(
  parameter int NW = 42,
  parameter int DW = 32,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [NW-1:0] quo
);
  logic [NW-1:0] acc;
  logic [DW-1:0] rem;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt;
  logic          run;
  logic [DW:0]   trial;
  logic          take;

  always_comb begin
    trial = {rem, acc[NW-1]};
    take  = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc   <= num;
        rem   <= '0;
        den_q <= den;
        cnt   <= CW'(NW);
        run   <= 1'b1;
      end else if (run) begin
        rem <= take ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
        acc <= {acc[NW-2:0], take};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quo = acc;
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_calc_pkg::*;
#(
  parameter int RATE_W    = 32,
  parameter int DIV_W     = 5,
  parameter int MUL_W     = 8,
  parameter int LP_W      = 6,
  parameter int FLOOR_KHZ = 5000,
  parameter int LP_KHZ    = 10000,
  localparam int ACT_W    = RATE_W + 10,
  localparam int WORD_W   = 3 + DIV_W + MUL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RATE_W-1:0] target_kbps,
  input  logic [RATE_W-1:0] ref_khz,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] cfg_word,
  output logic [ACT_W-1:0]  actual_kbps,
  output logic [LP_W-1:0]   lp_div_code,
  output logic              mul_ovf
);
  localparam int DIV_MAX = (1 << DIV_W) - 1;
  localparam int MUL_MAX = (1 << MUL_W) - 1;
  localparam int LP_DEN  = LP_KHZ * 8;

  calc_state_t       st;
  logic [RATE_W-1:0] tgt_q, ref_q;
  logic [DIV_W-1:0]  div_q;
  logic [ACT_W-1:0]  thr_q;
  logic [MUL_W-1:0]  mul_q, mul_eff;
  logic              ovf_q;
  logic [ACT_W-1:0]  act_q;
  logic [1:0]        band;

  logic              dv_go, dv_fin;
  logic [ACT_W-1:0]  dv_num, dv_quo;
  logic [RATE_W-1:0] dv_den;

  assign mul_eff = (mul_q == '0) ? MUL_W'(1) : mul_q;

  always_comb begin
    dv_go  = 1'b0;
    dv_num = '0;
    dv_den = '0;
    case (st)
      ST_MUL_GO: begin
        dv_go  = 1'b1;
        dv_num = ACT_W'(tgt_q) * ACT_W'(div_q) + ACT_W'(ref_q) - ACT_W'(1);
        dv_den = ref_q;
      end
      ST_ACT_GO: begin
        dv_go  = 1'b1;
        dv_num = ACT_W'(ref_q) * ACT_W'(mul_eff);
        dv_den = RATE_W'(div_q);
      end
      ST_LP_GO: begin
        dv_go  = 1'b1;
        dv_num = act_q + ACT_W'(LP_DEN - 1);
        dv_den = RATE_W'(LP_DEN);
      end
      default: ;
    endcase
  end

  pll_seq_div #(.NW(ACT_W), .DW(RATE_W)) u_div (
    .clk (clk),
    .rst (rst),
    .go  (dv_go),
    .num (dv_num),
    .den (dv_den),
    .fin (dv_fin),
    .quo (dv_quo)
  );

  pll_band_enc #(.ACT_W(ACT_W)) u_band (
    .rate (act_q),
    .band (band)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      tgt_q       <= '0;
      ref_q       <= '0;
      div_q       <= '0;
      thr_q       <= '0;
      mul_q       <= '0;
      ovf_q       <= 1'b0;
      act_q       <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      cfg_word    <= '0;
      actual_kbps <= '0;
      lp_div_code <= '0;
      mul_ovf     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          tgt_q <= target_kbps;
          ref_q <= ref_khz;
          div_q <= DIV_W'(1);
          thr_q <= ACT_W'(2 * FLOOR_KHZ);
          busy  <= 1'b1;
          st    <= ST_SEARCH;
        end
        ST_SEARCH: begin
          if (div_q < DIV_W'(DIV_MAX) && ACT_W'(ref_q) >= thr_q) begin
            div_q <= div_q + DIV_W'(1);
            thr_q <= thr_q + ACT_W'(FLOOR_KHZ);
          end else begin
            st <= ST_MUL_GO;
          end
        end
        ST_MUL_GO: st <= ST_MUL_WAIT;
        ST_MUL_WAIT: if (dv_fin) begin
          if (dv_quo > ACT_W'(MUL_MAX)) begin
            mul_q <= MUL_W'(MUL_MAX);
            ovf_q <= 1'b1;
          end else begin
            mul_q <= dv_quo[MUL_W-1:0];
            ovf_q <= 1'b0;
          end
          st <= ST_ACT_GO;
        end
        ST_ACT_GO: st <= ST_ACT_WAIT;
        ST_ACT_WAIT: if (dv_fin) begin
          act_q <= dv_quo;
          st    <= ST_LP_GO;
        end
        ST_LP_GO: st <= ST_LP_WAIT;
        ST_LP_WAIT: if (dv_fin) begin
          cfg_word    <= {band, 1'b0, div_q, mul_q};
          actual_kbps <= act_q;
          lp_div_code <= LP_W'(dv_quo - ACT_W'(1));
          mul_ovf     <= ovf_q;
          done        <= 1'b1;
          busy        <= 1'b0;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk #(
  parameter int RATE_W = 32,
  parameter int DIV_W  = 5,
  parameter int MUL_W  = 8,
  localparam int ACT_W  = RATE_W + 10,
  localparam int WORD_W = 3 + DIV_W + MUL_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] cfg_word,
  input logic [ACT_W-1:0]  actual_kbps,
  input logic              mul_ovf
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  a_r2_div_nonzero: assert property (@(posedge clk) disable iff (rst)
    done |-> (cfg_word[MUL_W+DIV_W-1:MUL_W] != '0));

  a_r4_ovf_saturates: assert property (@(posedge clk) disable iff (rst)
    (done && mul_ovf) |-> (cfg_word[MUL_W-1:0] == '1));

  a_r6_top_band: assert property (@(posedge clk) disable iff (rst)
    (done && actual_kbps >= ACT_W'(501000)) |-> (cfg_word[WORD_W-1 -: 3] == 3'b110));

  a_r6_low_band: assert property (@(posedge clk) disable iff (rst)
    (done && actual_kbps < ACT_W'(126000)) |-> (cfg_word[WORD_W-1 -: 3] == 3'b000));

  a_r10_hold_word: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_word) |-> done);

  a_r10_hold_rate: assert property (@(posedge clk) disable iff (rst)
    !$stable(actual_kbps) |-> done);
endmodule

bind pll_rate_calc pll_rate_calc_chk #(
  .RATE_W (RATE_W),
  .DIV_W  (DIV_W),
  .MUL_W  (MUL_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .cfg_word    (cfg_word),
  .actual_kbps (actual_kbps),
  .mul_ovf     (mul_ovf)
);

// File: tb/sim_pll_rate_calc.sv
`timescale 1ns/1ps
module sim_pll_rate_calc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] target_kbps = '0;
  logic [31:0] ref_in = '0;
  logic        busy, done, mul_ovf;
  logic [15:0] cfg_word;
  logic [41:0] actual_kbps;
  logic [5:0]  lp_div_code;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit chk_en = 1'b0;

  always #10 clk = ~clk;

  pll_rate_calc u0 (
    .clk (clk), .rst (rst), .start (start),
    .target_kbps (target_kbps), .ref_khz (ref_in),
    .busy (busy), .done (done), .cfg_word (cfg_word),
    .actual_kbps (actual_kbps), .lp_div_code (lp_div_code), .mul_ovf (mul_ovf)
  );

  // Behavioural reference
  longint m_word, m_act, m_lp, m_ovf;
  longint p_word, p_act, p_lp, p_ovf, p_lat;
  bit     m_busy, m_done;
  longint m_left;

  task automatic calc(input longint t, input longint r,
                      output longint word, output longint act,
                      output longint lp, output longint ovf, output longint lat);
    longint d, m, me, rng, q;
    d = 1;
    while (r / (d + 1) >= 5000) d++;
    if (d > 31) d = 31;
    m = (t * d + r - 1) / r;
    ovf = (m > 255) ? 1 : 0;
    if (m > 255) m = 255;
    me = (m == 0) ? 1 : m;
    act = r * me / d;
    if (act >= 501000)      rng = 3;
    else if (act >= 251000) rng = 2;
    else if (act >= 126000) rng = 1;
    else                    rng = 0;
    q = (act + 79999) / 80000;
    lp = (q - 1) & 63;
    word = (rng << 14) | (d << 8) | m;
    lat = d + 3 * 44;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_left = 0;
      m_word = 0; m_act = 0; m_lp = 0; m_ovf = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1;
          m_word = p_word; m_act = p_act; m_lp = p_lp; m_ovf = p_ovf;
        end
      end else if (start) begin
        calc(longint'(target_kbps), longint'(ref_in), p_word, p_act, p_lp, p_ovf, p_lat);
        m_left = p_lat;
        m_busy = 1;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      chk("R8 busy", longint'(busy), longint'(m_busy));
      chk("R8 done", longint'(done), longint'(m_done));
      chk("R2 divider", longint'(cfg_word[12:8]), (m_word >> 8) & 31);
      chk("R3 multiplier", longint'(cfg_word[7:0]), m_word & 255);
      chk("R4 overflow", longint'(mul_ovf), m_ovf);
      chk("R5/R10 actual", longint'(actual_kbps), m_act);
      chk("R6 band", longint'(cfg_word[15:13]), (m_word >> 13) & 7);
      chk("R7 lp code", longint'(lp_div_code), m_lp);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input longint t, input longint r);
    @(negedge clk);
    target_kbps = 32'(t);
    ref_in = 32'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    longint ew, ea, el, eo, lt;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 word", longint'(cfg_word), 0);
    chk("R1 actual", longint'(actual_kbps), 0);
    chk("R1 lp", longint'(lp_div_code), 0);
    chk("R1 ovf", longint'(mul_ovf), 0);
    rst = 1'b0;
    chk_en = 1'b1;
    @(negedge clk);

    run(300000, 24000);     // divider 4, band 2
    run(480000, 20000);
    run(1000000, 30000);    // band 3
    run(450000, 8000);      // divider 1
    run(900000, 200000);    // R2 clamp at 31
    run(300000, 3000);      // search stops at once
    run(0, 27000);          // R5 zero multiplier counted as 1
    run(5000000, 8000);     // R4 saturation
    run(501000, 3000);      // R6 exact top threshold
    run(500999, 3000);      // R6 rounded actual lifts band
    run(498000, 3000);
    run(126000, 3000);      // R6 lower boundary
    run(125000, 1000);
    run(80000, 1000);       // R7 exact lp boundary
    run(80001, 1000);
    run(250000, 5000);

    // R9: mid-run start with different operands is ignored
    @(negedge clk);
    target_kbps = 32'd600000;
    ref_in = 32'd25000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    target_kbps = 32'd90000;
    ref_in = 32'd9000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
    calc(600000, 25000, ew, ea, el, eo, lt);
    chk("R9 latched word", longint'(cfg_word), ew);
    chk("R9 latched actual", longint'(actual_kbps), ea);
    repeat (5) @(negedge clk);
    chk("R9 no restart busy", longint'(busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule